// File: doc/BRIEF.md
# Address-Pattern Bank Switch Controller

This block selects which 32 KB memory bank answers a host's bytewide memory cycles. Software never writes a bank register. It unlocks a selection by issuing a chain of ordinary read cycles whose address lines 8 to 11 spell out a fixed 16-step code. Only the last five A8 values are free. They carry a "select" flag and a 4-bit bank number. All other address lines play no part, so only the four pattern lines reach the block.

Chip enable, write enable and the four pattern lines are synchronised into the block clock. A read is recognised when chip enable rises with write enable high. The recogniser must first be aligned by one read with all four pattern lines high. Each of the next sixteen reads must then match its step. After the sixteenth matching read the new selection appears on the bank index and valid outputs. One active-low chip enable per populated bank follows the host's chip enable for the selected bank only. With no selection active, the block stays silent on a shared bus, which lets several units share one bus.

Top module: `bank_unlock_ctrl`

## Requirements
- R1: After reset, `bank_vld` is 0, `bank_idx` is 0 and every bit of `bank_cs_n` is 1.
- R2: A read is counted only when `ce_n` rises while `we_n` is high. Its nibble is `pat_addr`, with bit 0 = A8, bit 1 = A9, bit 2 = A10 and bit 3 = A11, as held during the low phase of `ce_n`.
- R3: A read with nibble 4'hF arms the recogniser, and the next read is step 0. A correct code sent without this alignment read changes nothing.
- R4: Steps 0 to 10 must carry, in order, the exact nibbles 5, A, 5, A, A, A, 5, 5, A, 7, 8.
- R5: Steps 11 to 15 must carry bits 3:1 equal to 010, 010, 010, 101, 101 in that order. Bit 0 (A8) is free in these steps.
- R6: A completed code with A8 = 0 at step 11 deselects all banks (`bank_vld` = 0, `bank_idx` = 0).
- R7: A completed code with A8 = 1 at step 11 selects bank {A8 at step 12, 13, 14, 15}, with step 12 as the MSB. The outputs keep their old value until the 16th read ends.
- R8: A mismatching read returns the recogniser to idle and leaves the selection unchanged. A mismatching read of 4'hF re-arms it at once.
- R9: Write cycles (`ce_n` low with `we_n` low) neither advance nor reset the recogniser.
- R10: While `pwr_ok` is low, all banks are deselected and the recogniser is idle.
- R11: A selected bank number at or above `NUM_BANKS` deselects all banks.
- R12: `bank_cs_n[i]` is low exactly when `ce_n` is low, `bank_vld` is 1 and `bank_idx` equals i. At most one bit is ever low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply good, synchronous to clk; low drops the selection |
| ce_n | input | 1 | Host chip enable, active low, asynchronous |
| we_n | input | 1 | Host write enable, active low, asynchronous |
| pat_addr | input | 4 | Host address lines A11..A8 (bit 0 = A8) |
| bank_idx | output | 4 | Selected bank number, 0 when none |
| bank_vld | output | 1 | A bank is selected |
| bank_cs_n | output | NUM_BANKS | Per-bank chip enable, active low |

## Verification
Two events can coincide on the same `ce_n` rising edge: the read that mismatches and the read that re-arms. The bench provokes this by breaking a code at each of the sixteen steps in turn and, separately, by inserting a 4'hF read part-way through a code. A broken code must leave the earlier bank in place. An all-ones read must let a fresh code complete straight away, with no second alignment read. The bench also checks that the selection holds through the 15th read and changes only after the 16th, across all sixteen bank numbers on a 12-bank build.

// File: rtl/bsw_pkg.sv
// Package: shared widths, the per-step code table and the selection type.
// Assumes the code is fixed at 16 steps on four address lines.
package bsw_pkg;
    localparam int STEPS     = 16;
    localparam int NIB_W     = 4;
    localparam int IDX_W     = 4;
    localparam int SEL_FIRST = 11;  // first step whose A8 is free

    typedef struct packed {
        logic [NIB_W-1:0] val;
        logic [NIB_W-1:0] care;
    } step_pat_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } bank_sel_t;

    // Expected nibble and compare mask for one step of the code.
    function automatic step_pat_t step_pattern(input logic [3:0] s);
        step_pat_t p;
        p.care = 4'hF;
        case (s)
            4'd0, 4'd2, 4'd6, 4'd7:          p.val = 4'h5;
            4'd1, 4'd3, 4'd4, 4'd5, 4'd8:    p.val = 4'hA;
            4'd9:                            p.val = 4'h7;
            4'd10:                           p.val = 4'h8;
            4'd11, 4'd12, 4'd13:             begin p.val = 4'h4; p.care = 4'hE; end
            default:                         begin p.val = 4'hA; p.care = 4'hE; end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/bsw_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes the bundle's bits are held stable for several clocks around
// each change, so the bits may move through the stages together.
module bsw_sync #(
    parameter int                WIDTH   = 6,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the bundle one stage closer to the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bsw_seq.sv
// Module: read-cycle detector and 16-step code recogniser; holds the
// bank selection. Assumes synchronised inputs; pwr_ok is already in the
// clk domain.
module bsw_seq
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic             ce_s,
    input  logic             we_s,
    input  logic [NIB_W-1:0] nib_s,
    output bank_sel_t        sel
);
    localparam logic [3:0] LAST = 4'(STEPS - 1);

    logic             ce_d, we_d;
    logic [NIB_W-1:0] nib_d;
    logic             armed;
    logic [3:0]       step;
    logic [3:0]       a8_hist;
    step_pat_t        pat;
    logic             match, cyc_end, rd_end, commit;
    logic [IDX_W-1:0] new_num;
    bank_sel_t        new_sel;

    // Delay the synchronised bus one clock so the edge sees its low-phase values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d  <= 1'b1;
            we_d  <= 1'b1;
            nib_d <= '0;
        end else begin
            ce_d  <= ce_s;
            we_d  <= we_s;
            nib_d <= nib_s;
        end
    end

    // Decode the end of a read and compare its nibble against the current step.
    always_comb begin
        cyc_end = ce_s & ~ce_d;
        rd_end  = cyc_end & we_d;
        pat     = step_pattern(step);
        match   = ((nib_d ^ pat.val) & pat.care) == '0;
        commit  = rd_end & armed & match & (step == LAST);
        new_num = {a8_hist[2:0], nib_d[0]};
        new_sel.vld = a8_hist[3] && (32'(new_num) < NUM_BANKS);
        new_sel.idx = new_sel.vld ? new_num : '0;
    end

    // Advance, abort or re-arm the recogniser and commit the selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            armed   <= 1'b0;
            step    <= '0;
            a8_hist <= '0;
            sel     <= '0;
        end else if (rd_end) begin
            if (armed && match) begin
                if (step == LAST) begin
                    armed <= 1'b0;
                    step  <= '0;
                    sel   <= new_sel;
                end else begin
                    step <= step + 4'd1;
                    if (32'(step) >= SEL_FIRST) a8_hist <= {a8_hist[2:0], nib_d[0]};
                end
            end else begin
                armed <= (nib_d == 4'hF);
                step  <= '0;
            end
        end
    end

    a_r3_align_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && rd_end && !armed && nib_d == 4'hF) |=> (armed && step == '0));
    a_r8_mismatch_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && rd_end && armed && !match && nib_d != 4'hF) |=> (!armed && $stable(sel)));
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && cyc_end && !we_d) |=> ($stable(armed) && $stable(step)));
    a_r7_sel_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !commit) |=> $stable(sel));
    a_r10_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!sel.vld && !armed));

    // R11: a selected bank is always a populated one.
    always @(posedge clk) begin
        if (rst_n) a_r11_idx_in_range: assert (!sel.vld || 32'(sel.idx) < NUM_BANKS);
    end
endmodule

// File: rtl/bsw_decode.sv
// Module: per-bank chip-enable decoder. Assumes ce_n is the raw host
// strobe so bank timing follows the host directly.
module bsw_decode
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  bank_sel_t            sel,
    output logic [NUM_BANKS-1:0] bank_cs_n
);
    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Enable this bank only when it is the selected one.
            assign bank_cs_n[b] = ~(~ce_n & sel.vld & (sel.idx == IDX_W'(b)));
        end
    endgenerate

    // R12: at most one bank enabled, and none while idle or deselected.
    always @(posedge clk) begin
        if (rst_n) begin
            a_r12_one_bank: assert ($onehot0(~bank_cs_n));
            a_r12_quiet_idle: assert (!(ce_n || !sel.vld) || (&bank_cs_n));
        end
    end
endmodule

// File: rtl/bank_unlock_ctrl.sv
// Module: top of the address-pattern bank switch. Synchronises the host
// strobes and pattern lines, recognises the unlock code and drives the
// per-bank chip enables. Assumes NUM_BANKS is in 1..16.
module bank_unlock_ctrl
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_ok,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic [NIB_W-1:0]     pat_addr,
    output logic [IDX_W-1:0]     bank_idx,
    output logic                 bank_vld,
    output logic [NUM_BANKS-1:0] bank_cs_n
);
    localparam int BUS_W = NIB_W + 2;

    logic [BUS_W-1:0] bus_s;
    bank_sel_t        sel;

    bsw_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, pat_addr}), .q(bus_s)
    );

    bsw_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .ce_s(bus_s[BUS_W-1]), .we_s(bus_s[BUS_W-2]), .nib_s(bus_s[NIB_W-1:0]),
        .sel(sel)
    );

    bsw_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel(sel), .bank_cs_n(bank_cs_n)
    );

    assign bank_idx = sel.idx;
    assign bank_vld = sel.vld;
endmodule

// File: tb/bank_unlock_ctrl_bench.sv
module bank_unlock_ctrl_bench;
    localparam int NB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    pat_addr = 4'h0;
    logic [3:0]    bank_idx;
    logic          bank_vld;
    logic [NB-1:0] bank_cs_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic       exp_vld = 1'b0;
    logic [3:0] exp_idx = 4'h0;

    // Code lines per step (index = step), from the requirements.
    localparam int L8  [11] = '{1,0,1,0,0,0,1,1,0,1,0};
    localparam int L9  [16] = '{0,1,0,1,1,1,0,0,1,1,0,0,0,0,1,1};
    localparam int L10 [16] = '{1,0,1,0,0,0,1,1,0,1,0,1,1,1,0,0};
    localparam int L11 [16] = '{0,1,0,1,1,1,0,0,1,0,1,0,0,0,1,1};

    always #2 clk = ~clk;  // 250 MHz

    bank_unlock_ctrl #(.NUM_BANKS(NB)) u_bank_unlock_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .we_n(we_n),
        .pat_addr(pat_addr), .bank_idx(bank_idx), .bank_vld(bank_vld),
        .bank_cs_n(bank_cs_n)
    );

    function automatic logic [3:0] nib(input int s, input logic [4:0] sel5);
        logic a8;
        a8 = (s < 11) ? (L8[s] != 0) : sel5[15 - s];
        return {L11[s] != 0, L10[s] != 0, L9[s] != 0, a8};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] n, input logic wr);
        @(negedge clk);
        pat_addr = n;
        we_n = ~wr;
        repeat (2) @(negedge clk);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] n);
        cyc(n, 1'b0);
    endtask

    task automatic steps(input int first, input int last, input logic [4:0] sel5);
        for (int s = first; s <= last; s++) rd(nib(s, sel5));
    endtask

    task automatic model(input logic [4:0] sel5);
        exp_vld = sel5[4] && (int'(sel5[3:0]) < NB);
        exp_idx = exp_vld ? sel5[3:0] : 4'h0;
    endtask

    task automatic chk_sel(input string tag);
        chk({bank_vld, bank_idx} == {exp_vld, exp_idx}, tag,
            {27'b0, bank_vld, bank_idx}, {27'b0, exp_vld, exp_idx});
    endtask

    // Pulse ce_n low in a write cycle (no effect on the recogniser) and check enables.
    task automatic chk_cs(input string tag);
        logic [NB-1:0] e;
        e = exp_vld ? ~(NB'(1) << exp_idx) : '1;
        @(negedge clk);
        chk(&bank_cs_n, tag, 32'(bank_cs_n), 32'({NB{1'b1}}));
        we_n = 1'b0;
        pat_addr = 4'h0;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        chk(bank_cs_n == e, tag, 32'(bank_cs_n), 32'(e));
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_sel("R1 reset selection");
        chk(&bank_cs_n, "R1 reset enables", 32'(bank_cs_n), 32'({NB{1'b1}}));

        // R3: correct code without the alignment read does nothing
        steps(0, 15, 5'b10011);
        chk_sel("R3 no alignment");

        // R7/R11/R5/R12: every bank number, A8 free bits vary
        for (int b = 0; b < 16; b++) begin
            rd(4'hF);
            steps(0, 14, {1'b1, 4'(b)});
            chk_sel("R7 held before 16th read");
            steps(15, 15, {1'b1, 4'(b)});
            model({1'b1, 4'(b)});
            chk_sel((b < NB) ? "R7 bank selected" : "R11 out of range");
            chk_cs("R12 chip enables");
            if (b >= NB) begin
                rd(4'hF); steps(0, 15, 5'b10010); model(5'b10010);
            end
        end

        // R6: deselect
        rd(4'hF); steps(0, 15, 5'b01111); model(5'b01111);
        chk_sel("R6 deselect");
        chk_cs("R6 enables quiet");

        // R4/R5/R8: break the code at every step (flip A9), selection must hold
        rd(4'hF); steps(0, 15, 5'b10011); model(5'b10011);
        for (int k = 0; k < 16; k++) begin
            rd(4'hF);
            steps(0, k - 1, 5'b10101);
            rd(nib(k, 5'b10101) ^ 4'h2);
            if (k < 15) steps(k + 1, 15, 5'b10101);
            chk_sel((k < 11) ? "R4 mismatch holds" : "R5 mismatch holds");
        end

        // R8: an all-ones mismatch re-arms immediately
        rd(4'hF); steps(0, 4, 5'b10111); rd(4'hF); steps(0, 15, 5'b10111);
        model(5'b10111);
        chk_sel("R8 re-arm on all ones");

        // R9: writes inside a code, including all-ones and mismatching nibbles
        rd(4'hF);
        for (int s = 0; s < 16; s++) begin
            rd(nib(s, 5'b10001));
            cyc(4'hF, 1'b1);
            cyc(4'h3, 1'b1);
        end
        model(5'b10001);
        chk_sel("R9 writes ignored");

        // R2: write cycles carrying a full code never select
        cyc(4'hF, 1'b1);
        for (int s = 0; s < 16; s++) cyc(nib(s, 5'b10100), 1'b1);
        chk_sel("R2 writes are not reads");

        // R10: power drop deselects and clears the recogniser
        rd(4'hF); steps(0, 6, 5'b10110);
        @(negedge clk); pwr_ok = 1'b0;
        repeat (2) @(negedge clk);
        model(5'b00000);
        chk_sel("R10 power drop");
        pwr_ok = 1'b1;
        steps(7, 15, 5'b10110);
        chk_sel("R10 recogniser cleared");
        chk_cs("R10 enables quiet");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule